// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is one bank of sixteen general-purpose pins with a small register interface of 16-bit words. Software sets each pin as an input or an output, drives output values through a latch, and reads back the level seen at each pin. Each pin can also raise an interrupt. A per-pin bit selects edge or level detection. A second per-pin bit picks the edge polarity, and a third picks the active level. A per-pin mask gates the latched status onto a single interrupt line that goes to a parent controller.

Input pins pass through a two-stage synchroniser, and all detection works on the synchronised value. Edge detection watches one polarity at a time. Software that wants both edges inverts the polarity bit after each serviced event, starting opposite to the current pin level. Software clears the latched status by writing zeros to it. A group of sleep, fault and alternate-function words is held as plain storage for use elsewhere in the chip.

Top module: `gpio_irq_bank`

## Requirements
- R1: Bit i of the direction word (offset 0) drives `pin_oe[i]`, where 1 means output. Bit i of the output word (offset 1) drives `pin_out[i]`. Both words reset to 0 and read back what was written.
- R2: The pin-level word (offset 2) is read-only. It returns `pin_in` delayed by two clock edges. After a single edge it still shows the previous value.
- R3: The mask word (offset 3) resets to 0xFFFF, where 1 means masked. `irq_out` is high exactly when some status bit is set and its mask bit is 0.
- R4: With trigger-type bit 1 (edge, offset 4) and edge-polarity bit 1 (offset 5), a rising pin sets its status bit on the third clock edge after the pin changes. A falling pin sets nothing.
- R5: With trigger-type bit 1 and edge-polarity bit 0, only a falling pin sets its status bit.
- R6: With trigger-type bit 0 (level), the status bit is set on every cycle in which the synchronised pin equals its level-polarity bit (offset 6, 1 = high, reset 0xFFFF). A clearing write has no lasting effect while the condition holds.
- R7: A write to the status word (offset 7) clears each bit written as 0 and keeps each bit written as 1. An event arriving in the same cycle as the clearing write wins. Status resets to 0.
- R8: The sleep-mask word (offset 8) resets to 0xFFFF. The sleep-output (9), fault-output (10), sleep-config (11) and alternate-function (12) words reset to 0. All five read back what was written.
- R9: Offsets 13 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch value |
| pin_oe | output | 16 | Output enable per pin |
| irq_out | output | 1 | Aggregated bank interrupt |

## Verification
A wrong polarity or trigger selection shows up as a status bit that sets on the wrong transition. A stale previous-sample register shows up as a status bit that is missing or spurious. Either error is visible at the status word and at `irq_out` three edges after the pin moves. A broken clear path shows up as a bit that survives a zero write, or as a level event lost under a simultaneous write, on the very next read. The sweeps walk every pin through each of the four detection modes, so a fault confined to one bit position cannot go unobserved.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word offsets; the bench and software decode these values.
  typedef enum logic [3:0] {
    OFS_DIR    = 4'd0,
    OFS_OUT    = 4'd1,
    OFS_PIN    = 4'd2,
    OFS_MASK   = 4'd3,
    OFS_TRIG   = 4'd4,
    OFS_EPOL   = 4'd5,
    OFS_LPOL   = 4'd6,
    OFS_STAT   = 4'd7,
    OFS_SLPMSK = 4'd8,
    OFS_SLPOUT = 4'd9,
    OFS_FLTOUT = 4'd10,
    OFS_SLPCFG = 4'd11,
    OFS_ALTFN  = 4'd12
  } gb_ofs_e;

  localparam int unsigned OFS_W = 4;

  function automatic logic ofs_is(input logic [OFS_W-1:0] a, input gb_ofs_e r);
    return a == r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  // One independent two-stage chain per pin.
  for (genvar g = 0; g < W; g++) begin : g_chain
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= raw_in[g];
        st2 <= st1;
      end
    end
    assign sync_out[g] = st2;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     trig_q,
  output logic [W-1:0]     epol_q,
  output logic [W-1:0]     lpol_q,
  output logic [W-1:0]     slpmsk_q,
  output logic [W-1:0]     slpout_q,
  output logic [W-1:0]     fltout_q,
  output logic [W-1:0]     slpcfg_q,
  output logic [W-1:0]     altfn_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      out_q    <= '0;
      mask_q   <= ALL_ONES;
      trig_q   <= '0;
      epol_q   <= '0;
      lpol_q   <= ALL_ONES;
      slpmsk_q <= ALL_ONES;
      slpout_q <= '0;
      fltout_q <= '0;
      slpcfg_q <= '0;
      altfn_q  <= '0;
    end else if (we) begin
      if (ofs_is(addr, OFS_DIR))    dir_q    <= wdata;
      if (ofs_is(addr, OFS_OUT))    out_q    <= wdata;
      if (ofs_is(addr, OFS_MASK))   mask_q   <= wdata;
      if (ofs_is(addr, OFS_TRIG))   trig_q   <= wdata;
      if (ofs_is(addr, OFS_EPOL))   epol_q   <= wdata;
      if (ofs_is(addr, OFS_LPOL))   lpol_q   <= wdata;
      if (ofs_is(addr, OFS_SLPMSK)) slpmsk_q <= wdata;
      if (ofs_is(addr, OFS_SLPOUT)) slpout_q <= wdata;
      if (ofs_is(addr, OFS_FLTOUT)) fltout_q <= wdata;
      if (ofs_is(addr, OFS_SLPCFG)) slpcfg_q <= wdata;
      if (ofs_is(addr, OFS_ALTFN))  altfn_q  <= wdata;
    end
  end

  // R1: a direction write lands on the next edge
  a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ofs_is(addr, OFS_DIR)) |=> (dir_q == $past(wdata)));
  // R3: mask only changes through a mask write
  a_r3_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && ofs_is(addr, OFS_MASK)) |=> $stable(mask_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_now,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  input  logic [W-1:0] mask,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] status,
  output logic [W-1:0] evt,
  output logic         irq
);
  logic [W-1:0] pin_prev;
  logic [W-1:0] keep;

  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] now, input logic [W-1:0] prev,
                                             input logic [W-1:0] pol);
    return (pol & now & ~prev) | (~pol & ~now & prev);
  endfunction

  function automatic logic [W-1:0] level_hits(input logic [W-1:0] now, input logic [W-1:0] pol);
    return ~(now ^ pol);
  endfunction

  assign evt  = (trig & edge_hits(pin_now, pin_prev, epol)) | (~trig & level_hits(pin_now, lpol));
  assign keep = clr_we ? clr_data : {W{1'b1}};
  assign irq  = |(status & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= '0;
      status   <= '0;
    end else begin
      pin_prev <= pin_now;
      status   <= (status & keep) | evt;
    end
  end

  // R4: every detected event is latched, even under a clearing write (R7)
  a_r4_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(evt)) == $past(evt)));
  // R7: bits written 1 (or not written) stay set
  a_r7_keep_uncleared: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & keep)) == $past(status & keep)));
  // R7: no bit sets without an event
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));
  // R3: fully masked bank stays quiet
  a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
  // R3: interrupt implies a latched source
  a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out
);
  logic [NPINS-1:0] pin_sync, evt;
  logic [NPINS-1:0] dir_q, out_q, mask_q, trig_q, epol_q, lpol_q;
  logic [NPINS-1:0] slpmsk_q, slpout_q, fltout_q, slpcfg_q, altfn_q, stat_q;
  logic             stat_wr;

  assign stat_wr = reg_we && ofs_is(reg_addr, OFS_STAT);

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regfile #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q), .trig_q(trig_q),
    .epol_q(epol_q), .lpol_q(lpol_q), .slpmsk_q(slpmsk_q), .slpout_q(slpout_q),
    .fltout_q(fltout_q), .slpcfg_q(slpcfg_q), .altfn_q(altfn_q)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_now(pin_sync), .trig(trig_q), .epol(epol_q),
    .lpol(lpol_q), .mask(mask_q), .clr_we(stat_wr), .clr_data(reg_wdata),
    .status(stat_q), .evt(evt), .irq(irq_out)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    case (reg_addr)
      OFS_DIR:    reg_rdata = dir_q;
      OFS_OUT:    reg_rdata = out_q;
      OFS_PIN:    reg_rdata = pin_sync;
      OFS_MASK:   reg_rdata = mask_q;
      OFS_TRIG:   reg_rdata = trig_q;
      OFS_EPOL:   reg_rdata = epol_q;
      OFS_LPOL:   reg_rdata = lpol_q;
      OFS_STAT:   reg_rdata = stat_q;
      OFS_SLPMSK: reg_rdata = slpmsk_q;
      OFS_SLPOUT: reg_rdata = slpout_q;
      OFS_FLTOUT: reg_rdata = fltout_q;
      OFS_SLPCFG: reg_rdata = slpcfg_q;
      OFS_ALTFN:  reg_rdata = altfn_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R9: unmapped offsets return zero
  a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > 4'd12) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam logic [3:0] DIR = 0, OUTW = 1, PIN = 2, MSK = 3, TRG = 4, EPL = 5,
                         LPL = 6, STA = 7, SMK = 8;

  logic        clk = 0, rst_n = 0, reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, pin_in = 0, pin_out, pin_oe;
  logic        irq_out;
  int nvec = 0, nfail = 0;

  gpio_irq_bank dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_rd(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    tick(3); rst_n = 1; tick(1);

    // Reset values
    chk_rd("R1 dir reset", DIR, 16'h0);
    chk_rd("R1 out reset", OUTW, 16'h0);
    chk_rd("R3 mask reset", MSK, 16'hFFFF);
    chk_rd("R6 lpol reset", LPL, 16'hFFFF);
    chk_rd("R7 status reset", STA, 16'h0);
    chk_rd("R8 sleep mask reset", SMK, 16'hFFFF);
    for (int a = 9; a <= 12; a++) chk_rd("R8 storage reset", 4'(a), 16'h0);
    chk("R3 irq reset", {15'h0, irq_out}, 16'h0);

    // R8 storage, R9 holes
    for (int a = 8; a <= 12; a++) begin
      wr(4'(a), 16'h1357 * 16'(a));
      chk_rd("R8 storage readback", 4'(a), 16'h1357 * 16'(a));
    end
    for (int a = 13; a <= 15; a++) begin
      wr(4'(a), 16'hFFFF);
      chk_rd("R9 hole reads zero", 4'(a), 16'h0);
    end
    chk_rd("R9 hole write no effect", DIR, 16'h0);

    // R1 direction and output latch
    for (int k = 0; k < 16; k++) begin
      wr(DIR, (16'h1 << k) ^ 16'h5A5A);
      wr(OUTW, ~(16'h1 << k));
      chk("R1 pin_oe", pin_oe, (16'h1 << k) ^ 16'h5A5A);
      chk("R1 pin_out", pin_out, ~(16'h1 << k));
    end
    wr(DIR, 0); wr(OUTW, 0);

    // R2 synchroniser latency (level hits latch here, but mask keeps irq low: R3)
    prev = 0;
    for (int k = 0; k < 16; k++) begin
      pin_in = (16'h1 << k) | (16'h8000 >> k) | 16'(k);
      tick(1);
      chk_rd("R2 pin not yet visible", PIN, prev);
      tick(1);
      chk_rd("R2 pin after two edges", PIN, pin_in);
      chk("R3 masked irq low", {15'h0, irq_out}, 16'h0);
      prev = pin_in;
    end
    pin_in = 0; tick(3); wr(STA, 0);
    chk_rd("R7 clear all", STA, 16'h0);

    // Masked event still latches
    wr(TRG, 16'hFFFF); wr(EPL, 16'hFFFF);
    pin_in = 16'h0010; tick(3);
    chk_rd("R3 masked event latched", STA, 16'h0010);
    chk("R3 masked irq stays low", {15'h0, irq_out}, 16'h0);
    pin_in = 0; tick(3); wr(STA, 0);

    // R4 rising-edge sweep
    for (int i = 0; i < 16; i++) begin
      wr(MSK, ~(16'h1 << i));
      pin_in = 16'h1 << i; tick(2);
      chk_rd("R4 no status before third edge", STA, 16'h0);
      tick(1);
      chk_rd("R4 rising latched", STA, 16'h1 << i);
      chk("R3 irq on unmasked", {15'h0, irq_out}, 16'h1);
      wr(STA, 0);
      chk_rd("R7 cleared", STA, 16'h0);
      chk("R3 irq drops", {15'h0, irq_out}, 16'h0);
      pin_in = 0; tick(3);
      chk_rd("R4 falling ignored", STA, 16'h0);
    end

    // R5 falling-edge sweep
    wr(EPL, 16'h0);
    for (int i = 0; i < 16; i++) begin
      wr(MSK, ~(16'h1 << i));
      pin_in = 16'h1 << i; tick(3);
      chk_rd("R5 rising ignored", STA, 16'h0);
      pin_in = 0; tick(3);
      chk_rd("R5 falling latched", STA, 16'h1 << i);
      chk("R3 irq falling", {15'h0, irq_out}, 16'h1);
      wr(STA, 0);
    end

    // R7 partial clear and same-cycle race
    wr(EPL, 16'hFFFF);
    pin_in = 16'h0081; tick(3);
    wr(STA, 16'h0080);
    chk_rd("R7 written-one bit kept", STA, 16'h0080);
    pin_in = 16'h0281; tick(2);
    wr(STA, 16'h0000);
    chk_rd("R7 event beats clear", STA, 16'h0200);
    pin_in = 0; tick(3); wr(STA, 0);

    // R6 level sweep
    wr(TRG, 16'h0);
    for (int i = 0; i < 16; i++) begin
      pin_in = 16'h1 << i; tick(3);
      chk_rd("R6 high level latched", STA, 16'h1 << i);
      wr(STA, 0);
      chk_rd("R6 held level re-sets", STA, 16'h1 << i);
      pin_in = 0; tick(3); wr(STA, 0);
      chk_rd("R6 released level clears", STA, 16'h0);
      wr(LPL, ~(16'h1 << i)); tick(1);
      chk_rd("R6 low level latched", STA, 16'h1 << i);
      wr(LPL, 16'hFFFF); wr(STA, 0);
      chk_rd("R6 low level cleared", STA, 16'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule